// File: doc/BRIEF.md
# Security Event Router

This block sits between the chip's security detectors (supply and clock monitors, tamper sensors, watchdogs, memory error checkers and similar) and the circuits that respond to them. It takes up to 48 event lines and drives seven response lines. The responses are an interrupt, a crypto engine reset, a key-store wipe, a RAM wipe, a chip reset and two tamper pins. For every pairing of a response line with an event line there is a routing field that can be set from a small register bus. A routing field can be locked, and only a reset clears the lock. Two event slots are software events. Software fires them by writing a nonzero value to a register.

Each event and each response has a sticky status bit. The status bit records that the event was seen or that the response was raised. It stays set until software clears it. A response line stays high as long as its status bit is set. Software can clear status bits one at a time or clear all of them at once. The detectors and the wipe and reset engines are outside this block.

Top module: `sec_event_router`

## Requirements
- R1: After reset, every routing field reads as disabled and unlocked, so a route word reads 0x55555555. Both status words read 0 and all response lines are low.
- R2: Response a and input i share one 2-bit field. The field sits in route word address a*3 + i/16, at bits [2*(i%16)+1 : 2*(i%16)]. Bit 0 of the field is an inverted enable: 0 routes the input to the response and 1 disables the route. Bit 1 of the field is the lock.
- R3: Once a field's lock bit is 1, bus writes leave both bits of that field unchanged. Software cannot clear the lock. Only a reset returns the field to disabled and unlocked.
- R4: A response line rises in the same cycle as any input routed to it. When several inputs are routed to one response, the response rises if any of them is high.
- R5: A response status bit sets on the clock edge that follows a routed event. The response line stays high after the event goes away, until its status bit is cleared.
- R6: An input status bit sets whenever its event is seen, whether or not the input is routed anywhere.
- R7: Writing a nonzero value to address 0x20 fires software event input 14 for one cycle. Writing a nonzero value to address 0x21 fires input 15 the same way. Writing zero to either address does nothing.
- R8: The first status word is at address 0x30. Its bits 15:0 hold inputs 0 to 15, and its bits 22:16 hold responses 0 to 6. The second status word is at address 0x31. Its bits 31:0 hold inputs 16 to 47.
- R9: Writing to a status word clears the status bits where the written data has ones. Writing any nonzero value to address 0x32 clears every status bit. If an event is present in the same cycle as a clear, the event keeps its bit set.
- R10: An event on an input whose route is disabled leaves every response line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low core reset. It also clears the locks. |
| evt_in | input | 48 | Event lines from the detectors, active high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| action_o | output | 7 | Response lines, active high |

## Verification
The bench targets the inverted enable. A design that treats 1 as "route" would drive the interrupt from every unconfigured input and would miss the routes the bench sets. The bench tries to rewrite a locked field and expects the field to keep its value until reset. A design that accepts the rewrite, or that lets software clear the lock, would read back a changed field. The bench writes zero to a software event register and expects no status bit to set. It also raises an event in the same cycle that its status bit is cleared, and expects the bit to stay set. A design that gives priority to the clear would lose that event. The bench checks selective clears of single bits in both status words. A design with the wrong bit layout, or one that clears too many bits, would change status bits it should have kept.

// File: rtl/sec_event_router.sv
module sec_event_router #(
  parameter int NE = 48,
  parameter int NA = 7,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] A_SW0 = 8'h20,
  parameter logic [AW-1:0] A_SW1 = 8'h21,
  parameter logic [AW-1:0] A_ST0 = 8'h30,
  parameter logic [AW-1:0] A_ST1 = 8'h31,
  parameter logic [AW-1:0] A_CLR = 8'h32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_in,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [NA-1:0] action_o
);
  localparam int G  = (NE + 15) / 16;
  localparam int HI = NE - 16;

  logic [NA*NE-1:0] dis_q, lk_q;
  logic [NE-1:0]    in_st, ev, clr_in;
  logic [NA-1:0]    out_st, hit, clr_out;
  logic [1:0]       sw_q;

  wire nz      = |bus_wdata;
  wire wr_st0  = bus_wr && bus_addr == A_ST0;
  wire wr_st1  = bus_wr && bus_addr == A_ST1;
  wire wr_clr  = bus_wr && bus_addr == A_CLR && nz;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dis_q <= '1;
      lk_q  <= '0;
    end else if (bus_wr) begin
      for (int a = 0; a < NA; a++)
        for (int i = 0; i < NE; i++)
          if (bus_addr == AW'(a*G + i/16) && !lk_q[a*NE+i]) begin
            dis_q[a*NE+i] <= bus_wdata[2*(i%16)];
            lk_q[a*NE+i]  <= bus_wdata[2*(i%16)+1];
          end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sw_q <= '0;
    else        sw_q <= {bus_wr && bus_addr == A_SW1 && nz,
                         bus_wr && bus_addr == A_SW0 && nz};

  always_comb begin
    ev = evt_in;
    ev[14] = evt_in[14] | sw_q[0];
    ev[15] = evt_in[15] | sw_q[1];
    for (int a = 0; a < NA; a++)
      hit[a] = |(ev & ~dis_q[a*NE +: NE]);
  end

  always_comb begin
    clr_in  = '0;
    clr_out = '0;
    if (wr_clr) begin
      clr_in  = '1;
      clr_out = '1;
    end
    if (wr_st0) begin
      clr_in[15:0] = clr_in[15:0] | bus_wdata[15:0];
      clr_out      = clr_out | bus_wdata[16 +: NA];
    end
    if (wr_st1) clr_in[NE-1:16] = clr_in[NE-1:16] | bus_wdata[HI-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_st  <= '0;
      out_st <= '0;
    end else begin
      in_st  <= (in_st & ~clr_in) | ev;
      out_st <= (out_st & ~clr_out) | hit;
    end

  assign action_o = hit | out_st;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ST0) begin
      bus_rdata[15:0]      = in_st[15:0];
      bus_rdata[16 +: NA]  = out_st;
    end else if (bus_addr == A_ST1) begin
      bus_rdata[HI-1:0] = in_st[NE-1:16];
    end else begin
      for (int a = 0; a < NA; a++)
        for (int i = 0; i < NE; i++)
          if (bus_addr == AW'(a*G + i/16)) begin
            bus_rdata[2*(i%16)]   = dis_q[a*NE+i];
            bus_rdata[2*(i%16)+1] = lk_q[a*NE+i];
          end
    end
  end

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lk_q) & ~lk_q) == '0));

  assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lk_q) & ($past(dis_q) ^ dis_q)) == '0));

  assert_status_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((out_st & $past(hit)) == $past(hit)));

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(out_st) & ~out_st)) |-> $past(wr_st0 || wr_clr));

  assert_sw_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SW0 && nz) |=> ##1 in_st[14]);
endmodule

// File: tb/sec_event_router_tb.sv
module sec_event_router_tb;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [47:0] evt_in = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd;
  logic [6:0]  action_o;
  int checks = 0, fails = 0;

  sec_event_router u_dut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .action_o(action_o));

  always #10 clk = ~clk;

  localparam int NV = 7;
  localparam logic [47:0] V_EVT [NV] = '{48'h1, 48'h2, 48'h2_0000_0000, 48'h2_0000_0002,
                                          48'h8000_0000_0001, 48'h20, 48'h4000};
  localparam logic [6:0]  V_ACT [NV] = '{7'h01, 7'h04, 7'h04, 7'h04, 7'h41, 7'h00, 7'h10};

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rdw(logic [7:0] a);
    @(negedge clk); bus_addr = a; #2 rd = bus_rdata;
  endtask

  function automatic logic [31:0] route1(int k);
    return 32'h5555_5555 & ~(32'h1 << (2*k));
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdw(8'h00); chk("R1 route word", rd, 32'h5555_5555);
    rdw(8'h30); chk("R1 status0", rd, 0);
    rdw(8'h31); chk("R1 status1", rd, 0);
    chk("R1 actions", {25'b0, action_o}, 0);

    // R2 route setup: a0<-in0, a2<-in1, a2<-in33, a4<-in14, a6<-in47
    wr(8'd0, route1(0));
    wr(8'd6, route1(1));
    wr(8'd8, route1(1));
    wr(8'd12, route1(14));
    wr(8'd20, route1(15));
    rdw(8'd6); chk("R2 readback", rd, route1(1));

    // R4 R5 R6 R8 R9 R10 vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); evt_in = V_EVT[v]; #2;
      chk("R4 R10 action same cycle", {25'b0, action_o}, {25'b0, V_ACT[v]});
      @(negedge clk); evt_in = '0; #2;
      chk("R5 action held", {25'b0, action_o}, {25'b0, V_ACT[v]});
      rdw(8'h30); chk("R6 R8 status0", rd, {9'b0, V_ACT[v], V_EVT[v][15:0]});
      rdw(8'h31); chk("R6 R8 status1", rd, V_EVT[v][47:16]);
      wr(8'h32, 32'h1);
      rdw(8'h30); chk("R9 clear-all status0", rd, 0);
      rdw(8'h31); chk("R9 clear-all status1", rd, 0);
      chk("R9 actions after clear", {25'b0, action_o}, 0);
    end

    // R3 lock: a1 group0 input2 routed and locked
    wr(8'd3, 32'h5555_5565);
    rdw(8'd3); chk("R3 locked readback", rd, 32'h5555_5565);
    wr(8'd3, 32'h5555_5555);
    rdw(8'd3); chk("R3 write ignored", rd, 32'h5555_5565);
    @(negedge clk); evt_in = 48'h4; #2;
    chk("R3 locked route active", {25'b0, action_o}, 7'h02);
    @(negedge clk); evt_in = '0;
    wr(8'h32, 32'h1);

    // R7 software events
    wr(8'h20, 32'h0); @(negedge clk);
    rdw(8'h30); chk("R7 zero write no event", rd, 0);
    wr(8'h20, 32'h5); @(negedge clk);
    rdw(8'h30); chk("R7 sw0 fires input 14", rd, 32'h0010_4000);
    chk("R7 sw0 drives action4", {25'b0, action_o}, 7'h10);
    wr(8'h32, 32'h1);
    wr(8'h21, 32'h8000_0000); @(negedge clk);
    rdw(8'h30); chk("R7 sw1 fires input 15", rd, 32'h0000_8000);
    wr(8'h32, 32'h1);

    // R9 selective clears
    @(negedge clk); evt_in = 48'h9;
    @(negedge clk); evt_in = '0;
    rdw(8'h30); chk("R9 before clear", rd, 32'h0001_0009);
    wr(8'h30, 32'h1);
    rdw(8'h30); chk("R9 clear input0 only", rd, 32'h0001_0008);
    wr(8'h30, 32'h1_0000);
    rdw(8'h30); chk("R9 clear action0", rd, 32'h8);
    chk("R9 action0 released", {25'b0, action_o}, 0);
    @(negedge clk); evt_in = 48'h2_0000_0000;
    @(negedge clk); evt_in = '0;
    wr(8'h30, 32'h0004_0000);
    rdw(8'h31); chk("R9 status1 bit17 kept", rd, 32'h0002_0000);
    wr(8'h31, 32'h0002_0000);
    rdw(8'h31); chk("R9 status1 cleared", rd, 0);
    // R9 set wins over clear
    @(negedge clk); bus_wr = 1; bus_addr = 8'h30; bus_wdata = 32'h8; evt_in = 48'h8;
    @(negedge clk); bus_wr = 0; evt_in = '0;
    rdw(8'h30); chk("R9 event beats clear", rd, 32'h8);

    // R3 reset clears lock
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rdw(8'd3); chk("R3 reset unlocks", rd, 32'h5555_5555);
    rdw(8'h30); chk("R1 status after reset", rd, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule